// File: doc/BRIEF.md
# Charge Cycle Sequencer

This block steps a single-cell linear charger through one charge cycle. It works only from digitized status flags that the analog front end supplies. The flags report the input supply condition, whether the battery is still below its low-voltage threshold, and whether the constant-voltage loop is in control. They also report whether the charge current has tapered to the termination level and whether another loop (input-voltage/power-path limiting, thermal regulation, or the warm temperature band) is shaping the current. From these flags the block drives the charge FET enable, a select that chooses the pre-charge or fast-charge current for the current DAC, and a 3-bit state code.

A cycle starts only when the input supply is valid and charging is permitted by both the active-low enable pin and the host disable bit. The block starts in pre-charge or fast charge depending on the battery level, and it guards each phase with a safety timer. Termination is accepted only when the current taper comes from the voltage loop itself. Whenever the current setting changes, the FET is held off for a blanking window of a programmable number of clock cycles. Losing the supply or the enable at any moment returns the block to idle.

Top module: `chg_cycle_seq`

## Requirements
- R1: The supply counts as valid only when `vin_uvlo_ok`=1, `vin_headroom_ok`=1 and `vin_ovp`=0; otherwise the state stays idle and `fet_en`=0.
- R2: Charging is permitted only with `ce_pin`=0 and `host_dis`=0; the other three combinations keep the state idle with `fet_en`=0.
- R3: From idle with charging allowed, the next state is pre-charge (`fast_sel`=0) if `batt_low`=1, else fast charge (`fast_sel`=1); pre-charge moves to fast charge once `batt_low` is 0.
- R4: The safety timer allows SAFETY_CYCLES clock cycles in fast charge and SAFETY_CYCLES/4 in pre-charge, counted from entry into the phase; on expiry the state becomes fault with `fet_en`=0.
- R5: In fast charge, with no blanking in progress, `cv_loop_on`=1 together with `iterm_hit`=1 moves the state to done with `fet_en`=0; `iterm_hit` without `cv_loop_on` does not.
- R6: Termination is withheld while `dpm_limit_on`=1 or `thermal_reg_on`=1.
- R7: Termination is withheld while `ts_warm`=1.
- R8: A one-cycle `iset_change` strobe, or the move from pre-charge to fast charge, holds `fet_en` at 0 for exactly BLANK_CYCLES sampled cycles while the state is kept. Entry from idle does not blank.
- R9: A new strobe during blanking restarts the full window, and termination is not evaluated until the window has ended.
- R10: Fault and done are held regardless of the battery and loop flags, until charging stops being allowed.
- R11: If the supply or the enable is lost in any state, the next state is idle, and the safety timer starts afresh on the next entry.
- R12: State codes are idle 3'd0, pre-charge 3'd1, fast charge 3'd2, done 3'd3, fault 3'd4; reset gives idle with `fet_en`=0 and `fast_sel`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vin_uvlo_ok | input | 1 | Input above undervoltage threshold |
| vin_headroom_ok | input | 1 | Input above battery plus sleep offset |
| vin_ovp | input | 1 | Input above overvoltage threshold |
| batt_low | input | 1 | Battery below low-voltage threshold |
| cv_loop_on | input | 1 | Constant-voltage loop in control |
| iterm_hit | input | 1 | Charge current at or below termination level |
| dpm_limit_on | input | 1 | Input-voltage or power-path limiting active |
| thermal_reg_on | input | 1 | Die thermal regulation active |
| ts_warm | input | 1 | Battery temperature in warm band |
| ce_pin | input | 1 | Charge enable pin, active low |
| host_dis | input | 1 | Host charge disable bit |
| iset_change | input | 1 | Strobe: charge current setting changed |
| fet_en | output | 1 | Charge FET enable |
| fast_sel | output | 1 | 1 = fast-charge current, 0 = pre-charge current |
| state_code | output | 3 | Current state code |

## Verification
The hardest case to reach is a second current-change strobe that lands part way through a blanking window while the termination flags are already asserted. It must restart the window, and termination must wait until the FET has come back on for one cycle. The stimulus first walks the block through pre-charge into fast charge and lets the first window run out. It then issues two strobes a few cycles apart and raises the termination flags straight after the second. The exact off-count and the cycle of the move to done are then compared. The safety timer limits are checked the same way: both phases run uninterrupted to expiry, and pre-charge is broken part way and restarted to show that the count begins again.

// File: rtl/chg_pkg.sv
package chg_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_PRE   = 3'd1,
        ST_FAST  = 3'd2,
        ST_DONE  = 3'd3,
        ST_FAULT = 3'd4
    } chg_state_e;

endpackage

// File: rtl/chg_run_gate.sv
// Combines supply qualification and charge permission into one run flag.
module chg_run_gate (
    input  logic vin_uvlo_ok,
    input  logic vin_headroom_ok,
    input  logic vin_ovp,
    input  logic ce_pin,
    input  logic host_dis,
    output logic supply_ok,
    output logic run
);
    logic permit;

    always_comb begin
        supply_ok = vin_uvlo_ok & vin_headroom_ok & ~vin_ovp;
        permit    = ~ce_pin & ~host_dis;
        run       = supply_ok & permit;
    end
endmodule

// File: rtl/chg_blank_timer.sv
// Holds the FET off for BLANK_CYCLES cycles after a trigger; a trigger restarts it.
module chg_blank_timer #(
    parameter int BLANK_CYCLES = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic trigger,
    output logic active
);
    localparam int BW = $clog2(BLANK_CYCLES + 1);

    typedef struct packed {
        logic [BW-1:0] cnt;
    } blank_s;

    blank_s r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (clear) begin
            r_d.cnt = '0;
        end else if (trigger) begin
            r_d.cnt = BW'(BLANK_CYCLES);
        end else if (r_q.cnt != '0) begin
            r_d.cnt = r_q.cnt - BW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign active = (r_q.cnt != '0);
endmodule

// File: rtl/chg_safety_timer.sv
// Counts cycles spent in a charging phase; limit is a quarter in pre-charge.
module chg_safety_timer #(
    parameter int SAFETY_CYCLES = 36000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic count_en,
    input  logic pre_phase,
    output logic expired
);
    localparam int TW        = $clog2(SAFETY_CYCLES + 1);
    localparam int PRE_LIMIT = SAFETY_CYCLES / 4;
    localparam logic [TW-1:0] FAST_LAST = TW'(SAFETY_CYCLES - 1);
    localparam logic [TW-1:0] PRE_LAST  = TW'(PRE_LIMIT - 1);

    typedef struct packed {
        logic [TW-1:0] cnt;
    } tmr_s;

    tmr_s r_d, r_q;
    logic [TW-1:0] last;

    always_comb begin
        last    = pre_phase ? PRE_LAST : FAST_LAST;
        expired = count_en && (r_q.cnt >= last);
        r_d     = r_q;
        if (restart) begin
            r_d.cnt = '0;
        end else if (count_en && !expired) begin
            r_d.cnt = r_q.cnt + TW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end
endmodule

// File: rtl/chg_cycle_seq.sv
// Charge cycle sequencer: idle -> pre/fast -> done, with safety fault and blanking.
module chg_cycle_seq
    import chg_pkg::*;
#(
    parameter int BLANK_CYCLES  = 1000,
    parameter int SAFETY_CYCLES = 36000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       vin_uvlo_ok,
    input  logic       vin_headroom_ok,
    input  logic       vin_ovp,
    input  logic       batt_low,
    input  logic       cv_loop_on,
    input  logic       iterm_hit,
    input  logic       dpm_limit_on,
    input  logic       thermal_reg_on,
    input  logic       ts_warm,
    input  logic       ce_pin,
    input  logic       host_dis,
    input  logic       iset_change,
    output logic       fet_en,
    output logic       fast_sel,
    output logic [2:0] state_code
);
    typedef struct packed {
        chg_state_e state;
    } seq_s;

    seq_s r_d, r_q;

    logic supply_ok;
    logic run;
    logic blank_on;
    logic blank_trig;
    logic tmr_restart;
    logic tmr_en;
    logic tmr_expired;
    logic loop_clean;
    logic term_ok;
    logic charging_q;

    chg_run_gate u_gate (
        .vin_uvlo_ok     (vin_uvlo_ok),
        .vin_headroom_ok (vin_headroom_ok),
        .vin_ovp         (vin_ovp),
        .ce_pin          (ce_pin),
        .host_dis        (host_dis),
        .supply_ok       (supply_ok),
        .run             (run)
    );

    chg_blank_timer #(.BLANK_CYCLES(BLANK_CYCLES)) u_blank (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (!run),
        .trigger (blank_trig),
        .active  (blank_on)
    );

    chg_safety_timer #(.SAFETY_CYCLES(SAFETY_CYCLES)) u_safety (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (tmr_restart),
        .count_en  (tmr_en),
        .pre_phase (r_q.state == ST_PRE),
        .expired   (tmr_expired)
    );

    always_comb begin
        charging_q = (r_q.state == ST_PRE) || (r_q.state == ST_FAST);
        loop_clean = !dpm_limit_on && !thermal_reg_on && !ts_warm;
        term_ok    = cv_loop_on && iterm_hit && loop_clean && !blank_on;
        tmr_en     = charging_q;

        r_d = r_q;
        unique case (r_q.state)
            ST_IDLE: begin
                if (run) r_d.state = batt_low ? ST_PRE : ST_FAST;
            end
            ST_PRE: begin
                if (tmr_expired)   r_d.state = ST_FAULT;
                else if (!batt_low) r_d.state = ST_FAST;
            end
            ST_FAST: begin
                if (term_ok)          r_d.state = ST_DONE;
                else if (tmr_expired) r_d.state = ST_FAULT;
            end
            ST_DONE:  r_d.state = ST_DONE;
            ST_FAULT: r_d.state = ST_FAULT;
            default:  r_d.state = ST_IDLE;
        endcase
        if (!run) r_d.state = ST_IDLE;

        tmr_restart = (r_d.state != r_q.state) || !run;
        blank_trig  = run && (iset_change ||
                      ((r_q.state == ST_PRE) && (r_d.state == ST_FAST)));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{state: ST_IDLE};
        else        r_q <= r_d;
    end

    assign fet_en     = charging_q && !blank_on && run && supply_ok;
    assign fast_sel   = (r_q.state == ST_FAST);
    assign state_code = r_q.state;
endmodule

// File: rtl/chg_cycle_seq_chk.sv
module chg_cycle_seq_chk
    import chg_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       vin_uvlo_ok,
    input logic       vin_headroom_ok,
    input logic       vin_ovp,
    input logic       cv_loop_on,
    input logic       iterm_hit,
    input logic       dpm_limit_on,
    input logic       thermal_reg_on,
    input logic       ts_warm,
    input logic       ce_pin,
    input logic       host_dis,
    input logic       fet_en,
    input logic [2:0] state_code
);
    logic allowed;
    assign allowed = vin_uvlo_ok && vin_headroom_ok && !vin_ovp && !ce_pin && !host_dis;

    assert_lost_run_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !allowed |=> (state_code == ST_IDLE));

    assert_state_legal_R12: assert property (@(posedge clk) disable iff (!rst_n)
        state_code <= 3'd4);

    assert_fet_only_charging_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fet_en |-> (state_code == ST_PRE || state_code == ST_FAST));

    assert_phase_blank_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == ST_FAST && $past(state_code) == ST_PRE) |-> !fet_en);

    // R6 and R7 are covered by the same qualification
    assert_term_qualified_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == ST_DONE && $past(state_code) == ST_FAST) |->
        $past(cv_loop_on && iterm_hit && !dpm_limit_on && !thermal_reg_on && !ts_warm));

    assert_fault_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_code) == ST_FAULT && $past(allowed)) |-> (state_code == ST_FAULT));
endmodule

bind chg_cycle_seq chg_cycle_seq_chk u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .vin_uvlo_ok     (vin_uvlo_ok),
    .vin_headroom_ok (vin_headroom_ok),
    .vin_ovp         (vin_ovp),
    .cv_loop_on      (cv_loop_on),
    .iterm_hit       (iterm_hit),
    .dpm_limit_on    (dpm_limit_on),
    .thermal_reg_on  (thermal_reg_on),
    .ts_warm         (ts_warm),
    .ce_pin          (ce_pin),
    .host_dis        (host_dis),
    .fet_en          (fet_en),
    .state_code      (state_code)
);

// File: tb/chg_cycle_seq_test.sv
module chg_cycle_seq_test;
    localparam int CLK_PERIOD = 10;
    localparam int BL = 8;
    localparam int SF = 64;
    localparam int PL = SF / 4;

    localparam logic [2:0] S_IDLE = 3'd0, S_PRE = 3'd1, S_FAST = 3'd2,
                           S_DONE = 3'd3, S_FAULT = 3'd4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic vin_uvlo_ok = 1'b0, vin_headroom_ok = 1'b1, vin_ovp = 1'b0;
    logic batt_low = 1'b1, cv_loop_on = 1'b0, iterm_hit = 1'b0;
    logic dpm_limit_on = 1'b0, thermal_reg_on = 1'b0, ts_warm = 1'b0;
    logic ce_pin = 1'b0, host_dis = 1'b0, iset_change = 1'b0;
    logic fet_en, fast_sel;
    logic [2:0] state_code;

    always #(CLK_PERIOD/2) clk = ~clk;

    chg_cycle_seq #(.BLANK_CYCLES(BL), .SAFETY_CYCLES(SF)) uut (
        .clk(clk), .rst_n(rst_n),
        .vin_uvlo_ok(vin_uvlo_ok), .vin_headroom_ok(vin_headroom_ok), .vin_ovp(vin_ovp),
        .batt_low(batt_low), .cv_loop_on(cv_loop_on), .iterm_hit(iterm_hit),
        .dpm_limit_on(dpm_limit_on), .thermal_reg_on(thermal_reg_on), .ts_warm(ts_warm),
        .ce_pin(ce_pin), .host_dis(host_dis), .iset_change(iset_change),
        .fet_en(fet_en), .fast_sel(fast_sel), .state_code(state_code)
    );

    typedef struct {
        bit         chk;
        string      req;
        logic [2:0] st;
        logic       fet;
        logic       sel;
    } exp_t;

    exp_t sb[$];
    int   n_checks = 0;
    int   n_fails  = 0;
    bit   finished = 1'b0;

    // Driver: queue the expectation for the result after the coming edge.
    task automatic tick(input string req, input logic [2:0] st, input logic fet, input logic sel);
        exp_t e;
        e.chk = 1'b1; e.req = req; e.st = st; e.fet = fet; e.sel = sel;
        sb.push_back(e);
        @(negedge clk);
    endtask

    // Monitor: sample one time unit after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                if (e.chk) begin
                    n_checks++;
                    if (state_code !== e.st || fet_en !== e.fet || fast_sel !== e.sel) begin
                        n_fails++;
                        $display("FAIL %s: state/fet/sel = %0d/%0b/%0b expected %0d/%0b/%0b",
                                 e.req, state_code, fet_en, fast_sel, e.st, e.fet, e.sel);
                    end
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_fails++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        // R12: reset state
        tick("R12", S_IDLE, 0, 0);
        tick("R12", S_IDLE, 0, 0);
        rst_n = 1'b1;

        // R1: each invalid supply condition keeps idle
        tick("R1", S_IDLE, 0, 0);
        vin_uvlo_ok = 1'b1; vin_headroom_ok = 1'b0;
        tick("R1", S_IDLE, 0, 0);
        vin_headroom_ok = 1'b1; vin_ovp = 1'b1;
        tick("R1", S_IDLE, 0, 0);
        vin_ovp = 1'b0;

        // R2: enable combinations
        ce_pin = 1'b1; host_dis = 1'b0; tick("R2", S_IDLE, 0, 0);
        ce_pin = 1'b0; host_dis = 1'b1; tick("R2", S_IDLE, 0, 0);
        ce_pin = 1'b1; host_dis = 1'b1; tick("R2", S_IDLE, 0, 0);
        ce_pin = 1'b0; host_dis = 1'b0;

        // R3 / R4: pre-charge then expiry at quarter limit
        tick("R3", S_PRE, 1, 0);
        for (int j = 2; j <= PL; j++) tick("R4", S_PRE, 1, 0);
        tick("R4", S_FAULT, 0, 0);

        // R10: fault latched, cleared by enable toggle
        batt_low = 1'b0;
        tick("R10", S_FAULT, 0, 0);
        tick("R10", S_FAULT, 0, 0);
        ce_pin = 1'b1;
        tick("R10", S_IDLE, 0, 0);
        ce_pin = 1'b0; batt_low = 1'b1;
        tick("R3", S_PRE, 1, 0);

        // R8: pre to fast blanks for BL cycles
        batt_low = 1'b0;
        for (int i = 0; i < BL; i++) tick("R8", S_FAST, 0, 1);
        tick("R8", S_FAST, 1, 1);

        // R6 / R7 / R5: termination withheld
        cv_loop_on = 1'b1; iterm_hit = 1'b1; dpm_limit_on = 1'b1;
        tick("R6", S_FAST, 1, 1); tick("R6", S_FAST, 1, 1);
        dpm_limit_on = 1'b0; thermal_reg_on = 1'b1;
        tick("R6", S_FAST, 1, 1); tick("R6", S_FAST, 1, 1);
        thermal_reg_on = 1'b0; ts_warm = 1'b1;
        tick("R7", S_FAST, 1, 1); tick("R7", S_FAST, 1, 1);
        ts_warm = 1'b0; cv_loop_on = 1'b0;
        tick("R5", S_FAST, 1, 1); tick("R5", S_FAST, 1, 1);
        iterm_hit = 1'b0;

        // R8 / R9: strobe, then restart mid window with termination pending
        iset_change = 1'b1; tick("R8", S_FAST, 0, 1);
        iset_change = 1'b0;
        tick("R8", S_FAST, 0, 1); tick("R8", S_FAST, 0, 1);
        iset_change = 1'b1; tick("R9", S_FAST, 0, 1);
        iset_change = 1'b0; cv_loop_on = 1'b1; iterm_hit = 1'b1;
        for (int i = 0; i < BL - 1; i++) tick("R9", S_FAST, 0, 1);
        tick("R9", S_FAST, 1, 1);
        tick("R5", S_DONE, 0, 0);

        // R10: done held; R11: supply loss returns idle
        cv_loop_on = 1'b0; iterm_hit = 1'b0;
        tick("R10", S_DONE, 0, 0); tick("R10", S_DONE, 0, 0);
        vin_uvlo_ok = 1'b0;
        tick("R11", S_IDLE, 0, 0);

        // R3 / R4: direct fast entry, no blank, full limit
        vin_uvlo_ok = 1'b1;
        tick("R3", S_FAST, 1, 1);
        for (int j = 2; j <= SF; j++) tick("R4", S_FAST, 1, 1);
        tick("R4", S_FAULT, 0, 0);
        vin_headroom_ok = 1'b0;
        tick("R10", S_IDLE, 0, 0);

        // R11: interrupted pre-charge restarts the timer
        vin_headroom_ok = 1'b1; batt_low = 1'b1;
        tick("R11", S_PRE, 1, 0);
        for (int j = 2; j <= 10; j++) tick("R11", S_PRE, 1, 0);
        host_dis = 1'b1;
        tick("R11", S_IDLE, 0, 0);
        host_dis = 1'b0;
        tick("R11", S_PRE, 1, 0);
        for (int j = 2; j <= PL; j++) tick("R11", S_PRE, 1, 0);
        tick("R11", S_FAULT, 0, 0);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end
endmodule